// File: doc/BRIEF.md
# Multi-Lane Pixel Steering Packer

This block takes a byte-wide stream of packed pixel symbols and spreads it over one, two or four main-link lanes, chosen at run time. Pixels are dealt to lanes in turn by their index within the active line. Each lane has its own small queue. All lanes share one transfer-unit position counter, so they stay in step. In every transfer unit a lane first sends queued pixels, up to a programmed valid count. It then sends a fill-start code, zero stuffing symbols and a fill-end code in the last slot of the unit.

The pixel that carries the end-of-line marker ends the active line. Once every active lane has sent all of its pixels from that line, the block cuts the current transfer unit short. It places a blanking-start code on all active lanes in one cycle and restarts the unit count. If a lane's queue runs dry inside the data portion while no line end is pending, the block raises an underflow flag and that lane stuffs the rest of the unit. Scrambling, 8b/10b coding and serialisation happen downstream.

Top module: `lane_steer_packer`

## Requirements
- R1: `lane_mode` selects the lane count: 0 gives one lane, 1 gives two lanes, 2 gives four lanes. Every lane at or above the count outputs symbol 0x00, code 0 and a clear control flag in every cycle.
- R2: The pixel with index k in a line goes to lane k mod N, where N is the lane count. Index 0 is the first pixel after reset or after an end-of-line pixel. Each lane emits its pixels in arrival order, one per data slot.
- R3: The transfer-unit position starts at 0 in the first output cycle after reset. It advances by one per cycle and wraps after `tu_len`-1. Pixel data appears only at positions below `tu_valid_cnt`, and fill-end appears only at position `tu_len`-1.
- R4: When a lane leaves its data portion before the last position, it emits fill-start once, then zero stuffing symbols (code 0), then fill-end at the last position. With `tu_valid_cnt` equal to `tu_len` no fill codes appear. With exactly one stuffing slot, only fill-end appears.
- R5: Codes on `lane_code` are 0 for data or stuffing, 1 for fill-start (byte 0xFE), 2 for fill-end (byte 0xF7) and 3 for blanking-start (byte 0xBC). `lane_ctl` is 1 exactly when the code is not 0.
- R6: After an end-of-line pixel is accepted, blanking-start appears on all active lanes in the same cycle. It appears in the first output cycle after all of that line's pixels have been emitted. The next cycle is position 0.
- R7: `underflow` is 1 in an output cycle exactly when an active lane, still inside its data portion with no line end pending, has no pixel. That lane then emits fill-start, or fill-end if it is at the last position.
- R8: While a line end is pending, a lane that runs out of pixels moves to stuffing without raising `underflow`.
- R9: While reset is asserted, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_valid | input | 1 | Pixel symbol present this cycle |
| pix_data | input | 8 | Pixel symbol byte |
| pix_eol | input | 1 | Marks the last pixel of the active line |
| lane_mode | input | 2 | Lane count select (0: 1, 1: 2, 2: 4) |
| tu_len | input | 7 | Transfer-unit length in symbols (32 to 64) |
| tu_valid_cnt | input | 7 | Data slots per transfer unit (at most tu_len) |
| lane_sym | output | 32 | One symbol byte per lane, lane 0 in the low byte |
| lane_ctl | output | 4 | Per-lane control flag |
| lane_code | output | 8 | Per-lane 2-bit code, lane 0 in the low bits |
| underflow | output | 1 | A lane ran dry inside its data portion |

## Verification
On every cycle, the assertions check several rules. Unused lanes stay idle. The position counter either steps or restarts. Reads never hit an empty queue and writes never hit a full one. Fill-start opens every stuffing run. An underflow event is followed by a fill code on that lane. Blanking-start appears on every active lane together. Pixel order per lane, the exact cycle of blanking-start after the last pixel drains, and underflow being raised or held off all depend on the stimulus history. Only the bench's sweep shows these. It covers every lane count, several unit lengths and valid counts, and lines whose pixel count does not divide evenly by the lane count.

// File: rtl/lsp_pkg.sv
package lsp_pkg;
  localparam int SYM_W = 8;

  localparam logic [1:0] CODE_DATA = 2'd0;
  localparam logic [1:0] CODE_FS   = 2'd1;
  localparam logic [1:0] CODE_FE   = 2'd2;
  localparam logic [1:0] CODE_BS   = 2'd3;

  localparam logic [SYM_W-1:0] BYTE_FS = 8'hFE;
  localparam logic [SYM_W-1:0] BYTE_FE = 8'hF7;
  localparam logic [SYM_W-1:0] BYTE_BS = 8'hBC;

  // Number of lanes in use for a given mode; unused encodings fall back to four.
  function automatic int lane_total(input logic [1:0] mode);
    case (mode)
      2'd0:    return 1;
      2'd1:    return 2;
      default: return 4;
    endcase
  endfunction

  // Byte placed on the lane for a control code.
  function automatic logic [SYM_W-1:0] code_byte(input logic [1:0] code);
    case (code)
      CODE_FS: return BYTE_FS;
      CODE_FE: return BYTE_FE;
      CODE_BS: return BYTE_BS;
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/lsp_lane_fifo.sv
module lsp_lane_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [AW:0]   count;
  logic          full;

  assign empty = (count == '0);
  assign full  = (count == (AW+1)'(DEPTH));
  assign dout  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + AW'(1);
      if (pop)  rd_ptr <= rd_ptr + AW'(1);
      count <= count + (AW+1)'(push) - (AW+1)'(pop);
    end
  end

  // R2
  fifo_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> (!push || pop));
endmodule

// File: rtl/lsp_tu_sequencer.sv
module lsp_tu_sequencer #(
  parameter int TU_W = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [TU_W-1:0] tu_len,
  input  logic            eol_in,
  input  logic            all_empty,
  output logic [TU_W-1:0] pos,
  output logic            last,
  output logic            bs_now,
  output logic            eol_pend
);
  assign last   = (pos == tu_len - TU_W'(1));
  assign bs_now = eol_pend && all_empty;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos      <= '0;
      eol_pend <= 1'b0;
    end else begin
      pos      <= (bs_now || last) ? '0 : pos + TU_W'(1);
      eol_pend <= eol_in || (eol_pend && !bs_now);
    end
  end

  // R6
  bs_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bs_now |=> (pos == '0));
  // R3
  pos_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (last && !bs_now) |=> (pos == '0));
  // R3
  pos_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!last && !bs_now) |=> (pos == $past(pos) + TU_W'(1)));
  // R6
  eol_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eol_pend && !bs_now) |=> eol_pend);
endmodule

// File: rtl/lsp_lane_framer.sv
module lsp_lane_framer
  import lsp_pkg::*;
#(
  parameter int TU_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic [TU_W-1:0]  pos,
  input  logic [TU_W-1:0]  tu_valid,
  input  logic             last,
  input  logic             bs_now,
  input  logic             eol_pend,
  input  logic             fifo_empty,
  input  logic [SYM_W-1:0] fifo_data,
  output logic             pop,
  output logic             uf_evt,
  output logic [SYM_W-1:0] sym_q,
  output logic [1:0]       code_q
);
  logic fill;
  logic in_data_win;

  assign in_data_win = !fill && (pos < tu_valid);
  assign pop    = active && !bs_now && in_data_win && !fifo_empty;
  assign uf_evt = active && !bs_now && in_data_win && fifo_empty && !eol_pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fill   <= 1'b0;
      sym_q  <= '0;
      code_q <= CODE_DATA;
    end else if (!active) begin
      fill   <= 1'b0;
      sym_q  <= '0;
      code_q <= CODE_DATA;
    end else if (bs_now) begin
      fill   <= 1'b0;
      sym_q  <= code_byte(CODE_BS);
      code_q <= CODE_BS;
    end else if (pop) begin
      sym_q  <= fifo_data;
      code_q <= CODE_DATA;
    end else if (last) begin
      fill   <= 1'b0;
      sym_q  <= code_byte(CODE_FE);
      code_q <= CODE_FE;
    end else if (!fill) begin
      fill   <= 1'b1;
      sym_q  <= code_byte(CODE_FS);
      code_q <= CODE_FS;
    end else begin
      sym_q  <= '0;
      code_q <= CODE_DATA;
    end
  end

  // R1
  idle_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (sym_q == '0 && code_q == CODE_DATA));
  // R2
  pop_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !fifo_empty);
  // R4
  fs_opens_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fill) |-> (code_q == CODE_FS));
  // R7
  uf_to_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    uf_evt |=> (code_q == CODE_FS || code_q == CODE_FE));
endmodule

// File: rtl/lane_steer_packer.sv
module lane_steer_packer
  import lsp_pkg::*;
#(
  parameter int NLANES     = 4,
  parameter int FIFO_DEPTH = 16,
  parameter int TU_W       = 7
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    pix_valid,
  input  logic [SYM_W-1:0]        pix_data,
  input  logic                    pix_eol,
  input  logic [1:0]              lane_mode,
  input  logic [TU_W-1:0]         tu_len,
  input  logic [TU_W-1:0]         tu_valid_cnt,
  output logic [NLANES*SYM_W-1:0] lane_sym,
  output logic [NLANES-1:0]       lane_ctl,
  output logic [NLANES*2-1:0]     lane_code,
  output logic                    underflow
);
  localparam int LIDX_W = $clog2(NLANES);

  logic [NLANES-1:0] act, push, pop, f_empty, uf_evt, bs_lane;
  logic [SYM_W-1:0]  f_dout [NLANES];
  logic [SYM_W-1:0]  sym_arr [NLANES];
  logic [1:0]        code_arr [NLANES];

  logic [LIDX_W-1:0] pix_idx, lane_mask, tgt;
  logic [TU_W-1:0]   pos;
  logic              last, bs_now, eol_pend, all_empty;

  // Round-robin steering by pixel index within the line.
  assign lane_mask = LIDX_W'(lane_total(lane_mode) - 1);
  assign tgt       = pix_idx & lane_mask;

  always_ff @(posedge clk) begin
    if (!rst_n) pix_idx <= '0;
    else if (pix_valid) pix_idx <= pix_eol ? '0 : (pix_idx + LIDX_W'(1)) & lane_mask;
  end

  assign all_empty = &(f_empty | ~act);

  lsp_tu_sequencer #(.TU_W(TU_W)) i_seq (
    .clk(clk), .rst_n(rst_n), .tu_len(tu_len),
    .eol_in(pix_valid && pix_eol), .all_empty(all_empty),
    .pos(pos), .last(last), .bs_now(bs_now), .eol_pend(eol_pend)
  );

  for (genvar l = 0; l < NLANES; l++) begin : g_lane
    assign act[l]  = (l < lane_total(lane_mode));
    assign push[l] = pix_valid && (tgt == LIDX_W'(l));

    lsp_lane_fifo #(.W(SYM_W), .DEPTH(FIFO_DEPTH)) i_fifo (
      .clk(clk), .rst_n(rst_n), .push(push[l]), .din(pix_data),
      .pop(pop[l]), .dout(f_dout[l]), .empty(f_empty[l])
    );

    lsp_lane_framer #(.TU_W(TU_W)) i_framer (
      .clk(clk), .rst_n(rst_n), .active(act[l]), .pos(pos),
      .tu_valid(tu_valid_cnt), .last(last), .bs_now(bs_now),
      .eol_pend(eol_pend), .fifo_empty(f_empty[l]), .fifo_data(f_dout[l]),
      .pop(pop[l]), .uf_evt(uf_evt[l]), .sym_q(sym_arr[l]), .code_q(code_arr[l])
    );

    assign lane_sym[l*SYM_W +: SYM_W] = sym_arr[l];
    assign lane_code[l*2 +: 2]        = code_arr[l];
    assign lane_ctl[l]                = (code_arr[l] != CODE_DATA);
    assign bs_lane[l]                 = (code_arr[l] == CODE_BS);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) underflow <= 1'b0;
    else        underflow <= |uf_evt;
  end

  // R6
  bs_all_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bs_lane[0] |-> ((bs_lane & act) == act));
  // R2
  steer_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(push) && ((push & ~act) == '0));
endmodule

// File: tb/test_lane_steer_packer.sv
module test_lane_steer_packer;
  localparam int NL = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        pix_valid = 1'b0, pix_eol = 1'b0;
  logic [7:0]  pix_data = '0;
  logic [1:0]  lane_mode = '0;
  logic [6:0]  tu_len = 7'd32, tu_valid_cnt = 7'd32;
  logic [31:0] lane_sym;
  logic [3:0]  lane_ctl;
  logic [7:0]  lane_code;
  logic        underflow;

  lane_steer_packer i_lane_steer_packer (
    .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_data(pix_data),
    .pix_eol(pix_eol), .lane_mode(lane_mode), .tu_len(tu_len),
    .tu_valid_cnt(tu_valid_cnt), .lane_sym(lane_sym), .lane_ctl(lane_ctl),
    .lane_code(lane_code), .underflow(underflow)
  );

  int n_chk = 0, n_fail = 0;
  logic [7:0] q [NL][64];
  int q_wr [NL];
  int q_rd [NL];
  bit stuffing [NL];
  int p, nl_act, bidx;
  bit pend_active, eol_prev, bs_seen;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h (pos %0d, lanes %0d)", req, act, exp, p, nl_act);
    end
  endtask

  function automatic logic [7:0] byte_for(input logic [1:0] c);
    return (c == 2'd1) ? 8'hFE : (c == 2'd2) ? 8'hF7 : (c == 2'd3) ? 8'hBC : 8'h00;
  endfunction

  task automatic check_cycle();
    bit all_empty, exp_bs, uf_exp, last;
    logic [7:0] s;
    logic [1:0] c;
    all_empty = 1'b1;
    for (int l = 0; l < nl_act; l++) if (q_rd[l] != q_wr[l]) all_empty = 1'b0;
    exp_bs = pend_active && all_empty;
    last   = (p == int'(tu_len) - 1);
    uf_exp = 1'b0;
    for (int l = 0; l < NL; l++) begin
      s = lane_sym[l*8 +: 8];
      c = lane_code[l*2 +: 2];
      if (l >= nl_act) begin
        chk(s == 8'h00 && c == 2'd0 && !lane_ctl[l], "R1", {s, 2'b0, c}, 0);
      end else begin
        if (c != 2'd0) chk(lane_ctl[l] && s == byte_for(c), "R5", s, byte_for(c));
        else           chk(!lane_ctl[l], "R5", lane_ctl[l], 0);
        if (exp_bs) begin
          chk(c == 2'd3, "R6", c, 3);
        end else if (stuffing[l]) begin
          if (last) chk(c == 2'd2, "R3", c, 2);
          else      chk(c == 2'd0 && s == 8'h00, "R4", s, 0);
        end else if (p < int'(tu_valid_cnt) && c == 2'd0) begin
          if (q_rd[l] < q_wr[l]) begin
            chk(s == q[l][q_rd[l]], "R2", s, q[l][q_rd[l]]);
            q_rd[l]++;
          end else begin
            chk(1'b0, "R2", s, 0);
          end
        end else begin
          if (p < int'(tu_valid_cnt) && !pend_active) uf_exp = 1'b1;
          if (last) chk(c == 2'd2, "R3", c, 2);
          else      chk(c == 2'd1, "R4", c, 1);
          stuffing[l] = 1'b1;
        end
      end
    end
    if (pend_active) chk(underflow == uf_exp, "R8", underflow, uf_exp);
    else             chk(underflow == uf_exp, "R7", underflow, uf_exp);
    if (exp_bs) begin
      p = 0;
      pend_active = 1'b0;
      bs_seen = 1'b1;
      for (int l = 0; l < NL; l++) stuffing[l] = 1'b0;
    end else if (last) begin
      p = 0;
      for (int l = 0; l < NL; l++) stuffing[l] = 1'b0;
    end else begin
      p++;
    end
  endtask

  task automatic tick(input bit v, input logic [7:0] d, input bit e);
    int ln;
    @(negedge clk);
    check_cycle();
    if (eol_prev) pend_active = 1'b1;
    pix_valid = v;
    pix_data  = d;
    pix_eol   = e;
    eol_prev  = v && e;
    if (v) begin
      ln = bidx % nl_act;
      q[ln][q_wr[ln]] = d;
      q_wr[ln]++;
      bidx = e ? 0 : bidx + 1;
    end
  endtask

  task automatic run_config(input logic [1:0] mode, input int len, input int vcnt);
    int lens [3];
    rst_n = 1'b0;
    pix_valid = 1'b0;
    pix_eol = 1'b0;
    lane_mode = mode;
    tu_len = 7'(len);
    tu_valid_cnt = 7'(vcnt);
    nl_act = 1 << mode;
    repeat (2) @(negedge clk);
    chk(lane_sym == '0 && lane_code == '0 && lane_ctl == '0 && !underflow, "R9", lane_sym, 0);
    p = 0; bidx = 0; pend_active = 1'b0; eol_prev = 1'b0;
    for (int l = 0; l < NL; l++) begin
      q_wr[l] = 0; q_rd[l] = 0; stuffing[l] = 1'b0;
    end
    rst_n = 1'b1;
    repeat (3) tick(1'b0, 8'h00, 1'b0);
    lens[0] = 3 * nl_act + 1;
    lens[1] = 12 * nl_act;
    lens[2] = 1;
    for (int k = 0; k < 3; k++) begin
      for (int l = 0; l < NL; l++) begin
        q_wr[l] = 0; q_rd[l] = 0;
      end
      bs_seen = 1'b0;
      for (int i = 0; i < lens[k]; i++)
        tick(1'b1, 8'(((k * 53 + i * 13 + len) % 255) + 1), i == lens[k] - 1);
      for (int w = 0; w < 400 && !bs_seen; w++) tick(1'b0, 8'h00, 1'b0);
      chk(bs_seen, "R6", bs_seen, 1);
      repeat (5) tick(1'b0, 8'h00, 1'b0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int m = 0; m < 3; m++) begin
      run_config(2'(m), 32, 32);
      run_config(2'(m), 32, 31);
      run_config(2'(m), 40, 10);
      run_config(2'(m), 64, 60);
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule